// File: doc/BRIEF.md
# DRAM Refresh and Address Multiplexer

This block connects a Z80-style processor bus to a 16K-by-1 dynamic RAM array whose 14-bit address is presented in two 7-bit halves. It samples the active-low memory-request and refresh strobes and the address bus A13:A0 on the system clock. From these samples it derives the DRAM row strobe and a field select, and drives seven multiplexed address lines. While memory request is inactive, the upper field A13:A7 is presented. While memory request is active, the lower field is presented.

During a refresh cycle, the lower field is not taken from A6:A0. It comes from a free-running 7-bit row counter instead. The counter steps once each time the refresh strobe becomes active, so the processor's own refresh register plays no part in choosing the refreshed row. A refresh sequence proceeds in this order:

1. The refresh strobe goes active first.
2. Memory request goes active and later inactive.
3. The refresh strobe is released.

The read and write strobes stay idle throughout and are not used by this block.

All outputs follow the registered samples. Every output therefore reflects the bus values seen at the previous rising clock edge.

Top module: `dram_refresh_mux`

## Requirements
- R1: While reset is high at a clock edge, the row counter clears to 0. After that edge, `ras_n` is 1, `row_sel` is 0, and `dram_addr` is 0 until new bus samples arrive.
- R2: `ras_n` is 0 in the cycle after `mreq_n` is sampled 0, and 1 in the cycle after `mreq_n` is sampled 1.
- R3: `row_sel` is 1 (lower field) in the cycle after `mreq_n` is sampled 0, and 0 (upper field) in the cycle after `mreq_n` is sampled 1.
- R4: In the cycle after `mreq_n` is sampled 1, `dram_addr` equals bits 13:7 of the address sampled at that edge. This holds whether or not refresh is active.
- R5: In the cycle after `mreq_n` is sampled 0 with `rfsh_n` sampled 1, `dram_addr` equals bits 6:0 of the sampled address.
- R6: The row counter increases by one at an edge where `rfsh_n` is sampled 0 and the previous sample of `rfsh_n` was 1. At every other edge it keeps its value, including while refresh is held active for many cycles.
- R7: In the cycle after `mreq_n` and `rfsh_n` are both sampled 0, `dram_addr` equals the row counter value. This value already includes the step for the current refresh, so the first refresh after reset presents row 1.
- R8: Once `rfsh_n` is sampled 1 again, a memory request presents bits 6:0 of the address rather than the counter.
- R9: The counter wraps from 127 to 0. The 128th refresh after reset presents row 0, and the 129th presents row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| addr | input | 14 | Processor address bus A13:A0 |
| dram_addr | output | 7 | Multiplexed DRAM address lines |
| ras_n | output | 1 | DRAM row strobe, active low |
| row_sel | output | 1 | Field select: 1 = lower field, 0 = upper field |

## Verification
The bench builds the block with its default row width of seven bits, giving a 14-bit bus. At that width the full 128-row counter period fits in a few hundred refresh sequences. This puts the wrap from 127 to 0, and the return to row 1 after it, within easy reach of a directed run. A reference model updated from the requirements is compared with all three outputs on every clock. Directed tasks cover the ordered refresh sequence, a refresh held across two memory requests, and a release followed by an ordinary access.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    // Default width of one DRAM address field (row or column half).
    localparam int ROW_W_DEF = 7;

    // Which half of the processor address is driven to the DRAM pins.
    typedef enum logic {
        FIELD_HIGH = 1'b0,
        FIELD_LOW  = 1'b1
    } field_sel_e;

    // Decoded strobe state passed from the sampler to the datapath.
    typedef struct packed {
        logic mem_act;     // registered: memory request active
        logic rfsh_act;    // registered: refresh active
        logic rfsh_start;  // combinational: refresh becoming active at this edge
    } strobe_t;

    // Memory request active selects the lower field.
    function automatic field_sel_e field_for(input logic mem_act);
        return mem_act ? FIELD_LOW : FIELD_HIGH;
    endfunction

    // Refresh starts when the new sample is active and the previous sample was idle.
    function automatic logic start_edge(input logic now_act, input logic prev_act);
        return now_act && !prev_act;
    endfunction

endpackage

// File: rtl/bus_strobe_sampler.sv
module bus_strobe_sampler
    import dram_mux_pkg::*;
#(
    parameter int ROW_W = ROW_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mreq_n,
    input  logic                 rfsh_n,
    input  logic [2*ROW_W-1:0]   addr,
    output strobe_t              strb,
    output logic [2*ROW_W-1:0]   addr_q
);
    localparam int ADDR_W = 2 * ROW_W;

    logic mem_act_q;
    logic rfsh_act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_act_q  <= 1'b0;
            rfsh_act_q <= 1'b0;
            addr_q     <= '0;
        end else begin
            mem_act_q  <= !mreq_n;
            rfsh_act_q <= !rfsh_n;
            addr_q     <= addr;
        end
    end

    always_comb begin
        strb.mem_act    = mem_act_q;
        strb.rfsh_act   = rfsh_act_q;
        strb.rfsh_start = start_edge(!rfsh_n, rfsh_act_q);
    end

    // R6: a refresh start is reported only once per low period of rfsh_n
    p_single_start_r6: assert property (@(posedge clk) disable iff (rst)
        strb.rfsh_start |=> !strb.rfsh_start);

    // R1: sampled address register is ADDR_W wide and cleared by reset
    p_addr_reset_r1: assert property (@(posedge clk)
        rst |=> (addr_q == {ADDR_W{1'b0}}));

endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter
    import dram_mux_pkg::*;
#(
    parameter int ROW_W = ROW_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [ROW_W-1:0] row_q
);
    localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= row_q + 1'b1;
        end
    end

    p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> (row_q == $past(row_q) + 1'b1));

    p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(row_q));

    p_row_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (step && row_q == ROW_LAST) |=> (row_q == '0));

    p_row_reset_r1: assert property (@(posedge clk)
        rst |=> (row_q == '0));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int ROW_W = ROW_W_DEF
) (
    input  strobe_t              strb,
    input  logic [2*ROW_W-1:0]   addr_q,
    input  logic [ROW_W-1:0]     row_q,
    output field_sel_e           sel,
    output logic [ROW_W-1:0]     dram_addr
);
    logic [ROW_W-1:0] low_field;

    assign sel = field_for(strb.mem_act);

    for (genvar b = 0; b < ROW_W; b++) begin : g_bit
        assign low_field[b] = strb.rfsh_act ? row_q[b] : addr_q[b];
        assign dram_addr[b] = (sel == FIELD_LOW) ? low_field[b] : addr_q[ROW_W + b];
    end

endmodule

// File: rtl/dram_refresh_mux.sv
module dram_refresh_mux
    import dram_mux_pkg::*;
#(
    parameter int ROW_W = ROW_W_DEF,
    localparam int ADDR_W = 2 * ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mreq_n,
    input  logic              rfsh_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              row_sel
);
    strobe_t           strb;
    logic [ADDR_W-1:0] addr_q;
    logic [ROW_W-1:0]  row_q;
    field_sel_e        sel;

    bus_strobe_sampler #(.ROW_W(ROW_W)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .mreq_n (mreq_n),
        .rfsh_n (rfsh_n),
        .addr   (addr),
        .strb   (strb),
        .addr_q (addr_q)
    );

    refresh_row_counter #(.ROW_W(ROW_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .step  (strb.rfsh_start),
        .row_q (row_q)
    );

    dram_addr_mux #(.ROW_W(ROW_W)) u_mux (
        .strb      (strb),
        .addr_q    (addr_q),
        .row_q     (row_q),
        .sel       (sel),
        .dram_addr (dram_addr)
    );

    assign ras_n   = !strb.mem_act;
    assign row_sel = (sel == FIELD_LOW);

    p_ras_assert_r2: assert property (@(posedge clk) disable iff (rst)
        !mreq_n |=> !ras_n);

    p_ras_release_r2: assert property (@(posedge clk) disable iff (rst)
        mreq_n |=> ras_n);

    p_sel_low_r3: assert property (@(posedge clk) disable iff (rst)
        !mreq_n |=> row_sel);

    p_sel_high_r3: assert property (@(posedge clk) disable iff (rst)
        mreq_n |=> !row_sel);

    p_high_field_r4: assert property (@(posedge clk) disable iff (rst)
        mreq_n |=> (dram_addr == $past(addr[ADDR_W-1:ROW_W])));

    p_low_field_r5: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && rfsh_n) |=> (dram_addr == $past(addr[ROW_W-1:0])));

    p_refresh_row_r7: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && !rfsh_n) |=> (dram_addr == row_q));

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ras_n && !row_sel && dram_addr == '0));

endmodule

// File: tb/test_dram_refresh_mux.sv
module test_dram_refresh_mux;

    localparam int ROW_W  = 7;
    localparam int ADDR_W = 2 * ROW_W;

    logic              clk    = 1'b0;
    logic              rst    = 1'b1;
    logic              mreq_n = 1'b1;
    logic              rfsh_n = 1'b1;
    logic [ADDR_W-1:0] addr   = '0;
    logic [ROW_W-1:0]  dram_addr;
    logic              ras_n;
    logic              row_sel;

    int n_cmp = 0;
    int n_bad = 0;
    logic mon_on = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dram_refresh_mux #(.ROW_W(ROW_W)) i_dram_refresh_mux (
        .clk       (clk),
        .rst       (rst),
        .mreq_n    (mreq_n),
        .rfsh_n    (rfsh_n),
        .addr      (addr),
        .dram_addr (dram_addr),
        .ras_n     (ras_n),
        .row_sel   (row_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements, updated at each rising edge.
    logic              m_mem  = 1'b0;
    logic              m_rfsh = 1'b0;
    logic [ROW_W-1:0]  m_row  = '0;
    logic [ADDR_W-1:0] m_addr = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_mem  <= 1'b0;
            m_rfsh <= 1'b0;
            m_row  <= '0;
            m_addr <= '0;
        end else begin
            if (!rfsh_n && !m_rfsh) m_row <= m_row + 1'b1;   // R6 / R9
            m_rfsh <= !rfsh_n;
            m_mem  <= !mreq_n;
            m_addr <= addr;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R2 ras_n model", ras_n, !m_mem);
            chk("R3 row_sel model", row_sel, m_mem);
            if (!m_mem)      chk("R4 upper field model", dram_addr, m_addr[ADDR_W-1:ROW_W]);
            else if (m_rfsh) chk("R7 refresh row model", dram_addr, m_row);
            else             chk("R5 lower field model", dram_addr, m_addr[ROW_W-1:0]);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mreq_n = 1'b1; rfsh_n = 1'b1; addr = 14'h2A5B;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One ordered refresh sequence; checks the row shown during memory request.
    task automatic do_refresh(input logic [ADDR_W-1:0] a, input int exp_row, input string tag);
        rfsh_n = 1'b0; addr = a;
        @(negedge clk);
        chk({tag, " upper field before request"}, dram_addr, a[ADDR_W-1:ROW_W]);
        mreq_n = 1'b0;
        @(negedge clk);
        chk({tag, " refresh row"}, dram_addr, exp_row);
        mreq_n = 1'b1;
        @(negedge clk);
        chk("R2 ras_n released", ras_n, 1'b1);
        rfsh_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1; addr = 14'h3FFF; mreq_n = 1'b0; rfsh_n = 1'b0;
        @(negedge clk);
        chk("R1 ras_n after reset", ras_n, 1'b1);
        chk("R1 row_sel after reset", row_sel, 1'b0);
        chk("R1 dram_addr after reset", dram_addr, 0);
        mreq_n = 1'b1; rfsh_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_normal_access();
        logic [ADDR_W-1:0] pats [4] = '{14'h0000, 14'h3FFF, 14'h2AD5, 14'h1C63};
        foreach (pats[i]) begin
            addr = pats[i]; mreq_n = 1'b1;
            @(negedge clk);
            chk("R4 upper field", dram_addr, pats[i][ADDR_W-1:ROW_W]);
            chk("R3 row_sel idle", row_sel, 1'b0);
            mreq_n = 1'b0;
            @(negedge clk);
            chk("R5 lower field", dram_addr, pats[i][ROW_W-1:0]);
            chk("R2 ras_n active", ras_n, 1'b0);
            chk("R3 row_sel active", row_sel, 1'b1);
            mreq_n = 1'b1;
            @(negedge clk);
            chk("R2 ras_n idle", ras_n, 1'b1);
        end
    endtask

    task automatic t_first_refreshes();
        do_reset();
        do_refresh(14'h1F80, 1, "R7 first");
        do_refresh(14'h007F, 2, "R7 second");
    endtask

    task automatic t_long_refresh();
        // R6: refresh held across two memory requests steps the counter once
        do_reset();
        rfsh_n = 1'b0; addr = 14'h155A;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            mreq_n = 1'b0;
            @(negedge clk);
            chk("R6 row held during long refresh", dram_addr, 1);
            mreq_n = 1'b1;
            @(negedge clk);
        end
        rfsh_n = 1'b1;
        @(negedge clk);
        // R8: after release an access shows the address low field again
        addr = 14'h2B2C; mreq_n = 1'b0;
        @(negedge clk);
        chk("R8 low field after release", dram_addr, 14'h2B2C & 14'h7F);
        mreq_n = 1'b1;
        @(negedge clk);
        do_refresh(14'h0000, 2, "R6 next refresh");
    endtask

    task automatic t_wrap();
        do_reset();
        for (int k = 1; k <= 129; k++) begin
            if (k >= 127) do_refresh(14'(k * 37), k % 128, "R9 wrap");
            else          do_refresh(14'(k * 37), k % 128, "R7 sweep");
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, R1-related run incomplete actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_normal_access();
        t_first_refreshes();
        t_long_refresh();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule